// File: doc/BRIEF.md
# Two-Rank Crosspoint Configuration Store

This block holds the control state of a 4×4 crosspoint switch: for every output, which input it takes, whether it is enabled and a 4-bit drive level code; for every input, a 4-bit equalizer code. A host programs it over a small parallel port made of a 4-bit address, a 4-bit data bus and active-low strobes for select, write, update and read. All strobes are level-sensitive and are sampled on the system clock.

Writes go into a staging rank that does not touch the switch. An update strobe moves the whole staging rank into the active rank in one clock edge, so a complete new configuration takes effect at once. Asserting write and update together writes straight through both ranks. Readback always shows the active rank. The active rank drives the switch control outputs, a per-input equalizer enable and a per-output drive current in mA. While the router runs the switch in direct mode, it can record its current connectivity into both ranks through a capture strobe, so that the settings survive the return to programmed mode.

Top module: `xbar_cfg_bank`

## Requirements
- R1: While rst_ni is low, both ranks take their defaults: output n selects input n, every output is disabled, every level code is 4'b0111 and every EQ code is 0.
- R2: With cs_ni, we_ni and mode_i low and upd_ni high, the clock edge stores data_i into the staging entry (or entries) named by addr_i; the active rank and all switch control outputs keep their values.
- R3: With cs_ni and upd_ni low and mode_i low, the clock edge copies every staging entry into the active rank, whatever addr_i, data_i and re_ni hold.
- R4: With cs_ni, we_ni and upd_ni all low (mode_i low), the written data reaches the active rank at the same clock edge, together with a copy of all other staging entries.
- R5: addr_i[3:2] picks the function and addr_i[1:0] the channel: 2'b00 is output connectivity with data_i[1:0] the input number and data_i[2] the enable (1 = on); 2'b01 is the output level code data_i[3:0]; 2'b11 is the input EQ code data_i[3:0].
- R6: Address 4'b1000 writes one connectivity/enable word to all outputs, 4'b1001 one level code to all outputs, and 4'b1011 one EQ code to all inputs.
- R7: With cs_ni and re_ni low, we_ni high and mode_i low, rd_oe_o is high and rd_data_o combinationally shows the active-rank entry at addr_i; connectivity entries read as {1'b0, enable, input}; otherwise rd_oe_o is low and rd_data_o is 0.
- R8: While cs_ni is high, we_ni, upd_ni and re_ni have no effect and all stored contents are kept.
- R9: While mode_i is high, we_ni, upd_ni and re_ni have no effect and rd_oe_o stays low.
- R10: eq_en_o[i] is low exactly when the active EQ code of input i is 0.
- R11: out_ma_o reports, per output, the drive current 2 + 2 × level code in mA as a 6-bit value.
- R12: Address 4'b1010 and the other addresses with addr_i[3:2] = 2'b10 other than the three broadcast ones ignore writes; every address with addr_i[3:2] = 2'b10 reads back 0.
- R13: With cap_i high, the clock edge loads cap_sel_i and cap_en_i into the connectivity entries of both ranks, taking priority over any write or update of those entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of both ranks |
| cs_ni | input | 1 | Active-low select for the control port |
| we_ni | input | 1 | Active-low write to the staging rank |
| upd_ni | input | 1 | Active-low copy of the staging rank to the active rank |
| re_ni | input | 1 | Active-low readback of the active rank |
| mode_i | input | 1 | High = direct mode, control strobes unused |
| addr_i | input | 4 | Function in [3:2], channel in [1:0] |
| data_i | input | 4 | Write data |
| cap_i | input | 1 | Capture of direct-mode connectivity |
| cap_sel_i | input | 8 | Captured input number, 2 bits per output |
| cap_en_i | input | 4 | Captured enable per output |
| rd_data_o | output | 4 | Readback data |
| rd_oe_o | output | 1 | Readback data valid / bus drive enable |
| out_sel_o | output | 8 | Active input number, 2 bits per output |
| out_en_o | output | 4 | Active enable per output |
| out_lvl_o | output | 16 | Active level code, 4 bits per output |
| out_ma_o | output | 24 | Drive current in mA, 6 bits per output |
| eq_code_o | output | 16 | Active EQ code, 4 bits per input |
| eq_en_o | output | 4 | Equalizer enable per input |

## Verification
The bench writes into the staging rank and checks that the switch outputs do not move until an update, which catches a design that writes straight into the active rank; it also reads back after a staging-only write, so a readback wired to the wrong rank shows up. Update is issued with junk on address, data and read, and transparent write is checked within a single edge, catching an update gated by decode or a write-through that lands one cycle late. Broadcast addresses, the undefined 1010 address, a connectivity write with bit 3 set, select held high and direct mode are each driven with live strobes, exposing wrong broadcast decode, writes leaking through the select or mode gating, and a readback that echoes bit 3. Capture and a mid-run reset confirm that direct-mode connectivity reaches both ranks and that the non-zero defaults return.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] LVL_RST = 4'b0111;
  localparam logic [CODE_W-1:0] EQ_RST  = '0;

  typedef enum logic [1:0] {
    FN_CONN  = 2'b00,
    FN_LVL   = 2'b01,
    FN_BCAST = 2'b10,
    FN_EQ    = 2'b11
  } fn_e;

  // channel field values that select a broadcast target under FN_BCAST
  localparam int unsigned BC_CONN = 0;
  localparam int unsigned BC_LVL  = 1;
  localparam int unsigned BC_EQ   = 3;
endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PORTS),
  localparam int unsigned ADDR_W = 2 + SEL_W
) (
  input  logic                 cs_ni,
  input  logic                 we_ni,
  input  logic                 upd_ni,
  input  logic                 re_ni,
  input  logic                 mode_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_PORTS-1:0] conn_we_o,
  output logic [NUM_PORTS-1:0] lvl_we_o,
  output logic [NUM_PORTS-1:0] eq_we_o,
  output logic                 upd_o,
  output logic                 rd_o
);
  logic             port_live;
  logic             wr;
  fn_e              fn;
  logic [SEL_W-1:0] chan;
  logic             bc_conn, bc_lvl, bc_eq;

  assign port_live = !cs_ni && !mode_i;
  assign wr        = port_live && !we_ni;
  assign upd_o     = port_live && !upd_ni;
  assign rd_o      = port_live && !re_ni && we_ni;

  assign fn   = fn_e'(addr_i[ADDR_W-1 -: 2]);
  assign chan = addr_i[SEL_W-1:0];

  assign bc_conn = (fn == FN_BCAST) && (chan == SEL_W'(BC_CONN));
  assign bc_lvl  = (fn == FN_BCAST) && (chan == SEL_W'(BC_LVL));
  assign bc_eq   = (fn == FN_BCAST) && (chan == SEL_W'(BC_EQ));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dec
    logic hit;
    assign hit          = (chan == SEL_W'(i));
    assign conn_we_o[i] = wr && (((fn == FN_CONN) && hit) || bc_conn);
    assign lvl_we_o[i]  = wr && (((fn == FN_LVL)  && hit) || bc_lvl);
    assign eq_we_o[i]   = wr && (((fn == FN_EQ)   && hit) || bc_eq);
  end
endmodule

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_PORTS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              conn_we_i,
  input  logic [NUM_PORTS-1:0]              lvl_we_i,
  input  logic [NUM_PORTS-1:0]              eq_we_i,
  input  logic                              upd_i,
  input  logic [CODE_W-1:0]                 data_i,
  input  logic                              cap_i,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]   cap_sel_i,
  input  logic [NUM_PORTS-1:0]              cap_en_i,
  output logic [NUM_PORTS-1:0][SEL_W-1:0]   act_sel_o,
  output logic [NUM_PORTS-1:0]              act_en_o,
  output logic [NUM_PORTS-1:0][CODE_W-1:0]  act_lvl_o,
  output logic [NUM_PORTS-1:0][CODE_W-1:0]  act_eq_o
);
  logic [NUM_PORTS-1:0][SEL_W-1:0]  stg_sel_q, stg_sel_d, act_sel_q, act_sel_d;
  logic [NUM_PORTS-1:0]             stg_en_q,  stg_en_d,  act_en_q,  act_en_d;
  logic [NUM_PORTS-1:0][CODE_W-1:0] stg_lvl_q, stg_lvl_d, act_lvl_q, act_lvl_d;
  logic [NUM_PORTS-1:0][CODE_W-1:0] stg_eq_q,  stg_eq_d,  act_eq_q,  act_eq_d;

  always_comb begin
    stg_sel_d = stg_sel_q;
    stg_en_d  = stg_en_q;
    stg_lvl_d = stg_lvl_q;
    stg_eq_d  = stg_eq_q;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (conn_we_i[i]) begin
        stg_sel_d[i] = data_i[SEL_W-1:0];
        stg_en_d[i]  = data_i[SEL_W];
      end
      if (lvl_we_i[i]) stg_lvl_d[i] = data_i;
      if (eq_we_i[i])  stg_eq_d[i]  = data_i;
    end
    if (cap_i) begin
      stg_sel_d = cap_sel_i;
      stg_en_d  = cap_en_i;
    end
  end

  // update copies the post-write staging value, giving write-through for free
  always_comb begin
    act_sel_d = upd_i ? stg_sel_d : act_sel_q;
    act_en_d  = upd_i ? stg_en_d  : act_en_q;
    act_lvl_d = upd_i ? stg_lvl_d : act_lvl_q;
    act_eq_d  = upd_i ? stg_eq_d  : act_eq_q;
    if (cap_i) begin
      act_sel_d = cap_sel_i;
      act_en_d  = cap_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        stg_sel_q[i] <= SEL_W'(i);
        act_sel_q[i] <= SEL_W'(i);
        stg_lvl_q[i] <= LVL_RST;
        act_lvl_q[i] <= LVL_RST;
        stg_eq_q[i]  <= EQ_RST;
        act_eq_q[i]  <= EQ_RST;
      end
      stg_en_q <= '0;
      act_en_q <= '0;
    end else begin
      stg_sel_q <= stg_sel_d;
      stg_en_q  <= stg_en_d;
      stg_lvl_q <= stg_lvl_d;
      stg_eq_q  <= stg_eq_d;
      act_sel_q <= act_sel_d;
      act_en_q  <= act_en_d;
      act_lvl_q <= act_lvl_d;
      act_eq_q  <= act_eq_d;
    end
  end

  assign act_sel_o = act_sel_q;
  assign act_en_o  = act_en_q;
  assign act_lvl_o = act_lvl_q;
  assign act_eq_o  = act_eq_q;
endmodule

// File: rtl/xbar_cfg_rdmux.sv
module xbar_cfg_rdmux
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PORTS),
  localparam int unsigned ADDR_W = 2 + SEL_W
) (
  input  logic                              rd_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]   act_sel_i,
  input  logic [NUM_PORTS-1:0]              act_en_i,
  input  logic [NUM_PORTS-1:0][CODE_W-1:0]  act_lvl_i,
  input  logic [NUM_PORTS-1:0][CODE_W-1:0]  act_eq_i,
  output logic [CODE_W-1:0]                 rd_data_o,
  output logic                              rd_oe_o
);
  fn_e              fn;
  logic [SEL_W-1:0] chan;
  logic [CODE_W-1:0] val;

  assign fn   = fn_e'(addr_i[ADDR_W-1 -: 2]);
  assign chan = addr_i[SEL_W-1:0];

  always_comb begin
    val = '0;
    unique case (fn)
      FN_CONN:  val[SEL_W:0] = {act_en_i[chan], act_sel_i[chan]};
      FN_LVL:   val = act_lvl_i[chan];
      FN_EQ:    val = act_eq_i[chan];
      default:  val = '0;
    endcase
  end

  assign rd_oe_o   = rd_i;
  assign rd_data_o = rd_i ? val : '0;
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PORTS),
  localparam int unsigned ADDR_W = 2 + SEL_W,
  localparam int unsigned MA_W   = CODE_W + 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_ni,
  input  logic                          we_ni,
  input  logic                          upd_ni,
  input  logic                          re_ni,
  input  logic                          mode_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CODE_W-1:0]             data_i,
  input  logic                          cap_i,
  input  logic [NUM_PORTS*SEL_W-1:0]    cap_sel_i,
  input  logic [NUM_PORTS-1:0]          cap_en_i,
  output logic [CODE_W-1:0]             rd_data_o,
  output logic                          rd_oe_o,
  output logic [NUM_PORTS*SEL_W-1:0]    out_sel_o,
  output logic [NUM_PORTS-1:0]          out_en_o,
  output logic [NUM_PORTS*CODE_W-1:0]   out_lvl_o,
  output logic [NUM_PORTS*MA_W-1:0]     out_ma_o,
  output logic [NUM_PORTS*CODE_W-1:0]   eq_code_o,
  output logic [NUM_PORTS-1:0]          eq_en_o
);
  logic [NUM_PORTS-1:0]             conn_we, lvl_we, eq_we;
  logic                             upd, rd;
  logic [NUM_PORTS-1:0][SEL_W-1:0]  act_sel;
  logic [NUM_PORTS-1:0]             act_en;
  logic [NUM_PORTS-1:0][CODE_W-1:0] act_lvl, act_eq;

  xbar_cfg_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
    .cs_ni    (cs_ni),
    .we_ni    (we_ni),
    .upd_ni   (upd_ni),
    .re_ni    (re_ni),
    .mode_i   (mode_i),
    .addr_i   (addr_i),
    .conn_we_o(conn_we),
    .lvl_we_o (lvl_we),
    .eq_we_o  (eq_we),
    .upd_o    (upd),
    .rd_o     (rd)
  );

  xbar_cfg_store #(.NUM_PORTS(NUM_PORTS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .conn_we_i(conn_we),
    .lvl_we_i (lvl_we),
    .eq_we_i  (eq_we),
    .upd_i    (upd),
    .data_i   (data_i),
    .cap_i    (cap_i),
    .cap_sel_i(cap_sel_i),
    .cap_en_i (cap_en_i),
    .act_sel_o(act_sel),
    .act_en_o (act_en),
    .act_lvl_o(act_lvl),
    .act_eq_o (act_eq)
  );

  xbar_cfg_rdmux #(.NUM_PORTS(NUM_PORTS)) u_rdmux (
    .rd_i     (rd),
    .addr_i   (addr_i),
    .act_sel_i(act_sel),
    .act_en_i (act_en),
    .act_lvl_i(act_lvl),
    .act_eq_i (act_eq),
    .rd_data_o(rd_data_o),
    .rd_oe_o  (rd_oe_o)
  );

  assign out_sel_o = act_sel;
  assign out_en_o  = act_en;
  assign out_lvl_o = act_lvl;
  assign eq_code_o = act_eq;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lane
    assign eq_en_o[i] = |act_eq[i];
    assign out_ma_o[i*MA_W +: MA_W] = MA_W'(2) + {act_lvl[i], 1'b0};
  end
endmodule

// File: rtl/xbar_cfg_bank_chk.sv
module xbar_cfg_bank_chk
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PORTS),
  localparam int unsigned ADDR_W = 2 + SEL_W,
  localparam int unsigned MA_W   = CODE_W + 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cs_ni,
  input logic                          upd_ni,
  input logic                          mode_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          cap_i,
  input logic [CODE_W-1:0]             rd_data_o,
  input logic                          rd_oe_o,
  input logic [NUM_PORTS*SEL_W-1:0]    out_sel_o,
  input logic [NUM_PORTS-1:0]          out_en_o,
  input logic [NUM_PORTS*CODE_W-1:0]   out_lvl_o,
  input logic [NUM_PORTS*MA_W-1:0]     out_ma_o,
  input logic [NUM_PORTS*CODE_W-1:0]   eq_code_o,
  input logic [NUM_PORTS-1:0]          eq_en_o
);
  a_r2_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ni && !cap_i) |=> ($stable(out_sel_o) && $stable(out_en_o) &&
                            $stable(out_lvl_o) && $stable(eq_code_o)));

  a_r8_cs_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !cap_i) |=> ($stable(out_sel_o) && $stable(out_en_o) &&
                           $stable(out_lvl_o) && $stable(eq_code_o)));

  a_r9_mode_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !rd_oe_o);

  a_r7_conn_bit3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && addr_i[ADDR_W-1 -: 2] == 2'b00) |-> !rd_data_o[CODE_W-1]);

  a_r7_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> (rd_data_o == '0));

  a_r12_bcast_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && addr_i[ADDR_W-1 -: 2] == 2'b10) |-> (rd_data_o == '0));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    a_r10_eq_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eq_en_o[i] == (eq_code_o[i*CODE_W +: CODE_W] != '0));
    a_r11_drive_ma: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_ma_o[i*MA_W +: MA_W] == 2 * (MA_W'(out_lvl_o[i*CODE_W +: CODE_W]) + 1));
  end
endmodule

bind xbar_cfg_bank xbar_cfg_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .upd_ni   (upd_ni),
  .mode_i   (mode_i),
  .addr_i   (addr_i),
  .cap_i    (cap_i),
  .rd_data_o(rd_data_o),
  .rd_oe_o  (rd_oe_o),
  .out_sel_o(out_sel_o),
  .out_en_o (out_en_o),
  .out_lvl_o(out_lvl_o),
  .out_ma_o (out_ma_o),
  .eq_code_o(eq_code_o),
  .eq_en_o  (eq_en_o)
);

// File: tb/xbar_cfg_bank_bench.sv
module xbar_cfg_bank_bench;
  localparam int P  = 4;
  localparam int SW = 2;
  localparam int CW = 4;
  localparam int MW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, we_ni = 1'b1, upd_ni = 1'b1, re_ni = 1'b1, mode_i = 1'b0;
  logic [3:0] addr_i = '0, data_i = '0;
  logic cap_i = 1'b0;
  logic [P*SW-1:0] cap_sel_i = '0;
  logic [P-1:0] cap_en_i = '0;
  logic [CW-1:0] rd_data_o;
  logic rd_oe_o;
  logic [P*SW-1:0] out_sel_o;
  logic [P-1:0] out_en_o;
  logic [P*CW-1:0] out_lvl_o;
  logic [P*MW-1:0] out_ma_o;
  logic [P*CW-1:0] eq_code_o;
  logic [P-1:0] eq_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int s_sel[P], s_en[P], s_lvl[P], s_eq[P];
  int a_sel[P], a_en[P], a_lvl[P], a_eq[P];

  always #5 clk_i = ~clk_i;

  xbar_cfg_bank u_xbar_cfg_bank (.*);

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < P; i++) begin
      s_sel[i] = i; a_sel[i] = i; s_en[i] = 0; a_en[i] = 0;
      s_lvl[i] = 7; a_lvl[i] = 7; s_eq[i] = 0; a_eq[i] = 0;
    end
  endtask

  task automatic model_write(int a, int d);
    int f, c;
    f = a >> 2; c = a & 3;
    if (f == 0) begin s_sel[c] = d & 3; s_en[c] = (d >> 2) & 1; end
    else if (f == 1) s_lvl[c] = d;
    else if (f == 3) s_eq[c] = d;
    else if (a == 8) for (int i = 0; i < P; i++) begin s_sel[i] = d & 3; s_en[i] = (d >> 2) & 1; end
    else if (a == 9) for (int i = 0; i < P; i++) s_lvl[i] = d;
    else if (a == 11) for (int i = 0; i < P; i++) s_eq[i] = d;
  endtask

  task automatic model_update();
    for (int i = 0; i < P; i++) begin
      a_sel[i] = s_sel[i]; a_en[i] = s_en[i]; a_lvl[i] = s_lvl[i]; a_eq[i] = s_eq[i];
    end
  endtask

  function automatic int exp_read(int a);
    int f, c;
    f = a >> 2; c = a & 3;
    case (f)
      0: return (a_en[c] << 2) | a_sel[c];
      1: return a_lvl[c];
      3: return a_eq[c];
      default: return 0;
    endcase
  endfunction

  task automatic check_outputs(string req);
    for (int i = 0; i < P; i++) begin
      check(req, $sformatf("sel[%0d]", i), int'(out_sel_o[i*SW +: SW]), a_sel[i]);
      check(req, $sformatf("en[%0d]", i), int'(out_en_o[i]), a_en[i]);
      check(req, $sformatf("lvl[%0d]", i), int'(out_lvl_o[i*CW +: CW]), a_lvl[i]);
      check(req, $sformatf("eq[%0d]", i), int'(eq_code_o[i*CW +: CW]), a_eq[i]);
      check("R10", $sformatf("eq_en[%0d]", i), int'(eq_en_o[i]), int'(a_eq[i] != 0));
      check("R11", $sformatf("ma[%0d]", i), int'(out_ma_o[i*MW +: MW]), 2 + 2 * a_lvl[i]);
    end
  endtask

  // one sampled cycle of the control port, then back to idle
  task automatic port_cycle(bit cs, bit we, bit upd, bit re, int a, int d);
    @(negedge clk_i);
    cs_ni = cs; we_ni = we; upd_ni = upd; re_ni = re;
    addr_i = 4'(a); data_i = 4'(d);
    @(negedge clk_i);
    if (!cs && !mode_i) begin
      if (!we) model_write(a, d);
      if (!upd) model_update();
    end
    cs_ni = 1; we_ni = 1; upd_ni = 1; re_ni = 1;
  endtask

  task automatic do_read(string req, int a);
    @(negedge clk_i);
    cs_ni = 0; re_ni = 0; we_ni = 1; addr_i = 4'(a);
    #1;
    check(req, "rd_oe", int'(rd_oe_o), int'(!mode_i));
    check(req, $sformatf("rd_data@%0h", a), int'(rd_data_o), mode_i ? 0 : exp_read(a));
    cs_ni = 1; re_ni = 1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    #2;
    model_reset();
    check_outputs("R1");
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check_outputs("R1");
    do_read("R1", 4'b0010);
    do_read("R1", 4'b0111);
  endtask

  task automatic t_stage_then_update();
    port_cycle(0, 0, 1, 1, 4'b0010, 4'b0101);
    check_outputs("R2");
    do_read("R7", 4'b0010);
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R3");
    do_read("R7", 4'b0010);
  endtask

  task automatic t_fields();
    port_cycle(0, 0, 1, 1, 4'b0101, 4'd3);
    port_cycle(0, 0, 1, 1, 4'b1111, 4'd5);
    port_cycle(0, 0, 1, 1, 4'b0011, 4'b0100);
    check_outputs("R2");
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R5");
    do_read("R5", 4'b0101);
    do_read("R5", 4'b1111);
    do_read("R5", 4'b0011);
  endtask

  task automatic t_broadcast();
    port_cycle(0, 0, 1, 1, 4'b1000, 4'b0110);
    port_cycle(0, 0, 1, 1, 4'b1001, 4'hF);
    port_cycle(0, 0, 1, 1, 4'b1011, 4'd9);
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R6");
    do_read("R6", 4'b1000);
  endtask

  task automatic t_transparent();
    port_cycle(0, 0, 0, 1, 4'b0100, 4'd1);
    check_outputs("R4");
    check("R4", "lvl0", int'(out_lvl_o[3:0]), 1);
  endtask

  task automatic t_update_junk();
    port_cycle(0, 0, 1, 1, 4'b1110, 4'd2);
    check_outputs("R2");
    port_cycle(0, 1, 0, 0, 4'b0001, 4'hF);
    check_outputs("R3");
    check("R3", "eq2", int'(eq_code_o[11:8]), 2);
  endtask

  task automatic t_cs_high();
    port_cycle(1, 0, 0, 1, 4'b1100, 4'd7);
    check_outputs("R8");
    port_cycle(1, 1, 1, 0, 4'b1100, 0);
    check("R8", "rd_oe", int'(rd_oe_o), 0);
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R8");
  endtask

  task automatic t_mode_high();
    @(negedge clk_i) mode_i = 1;
    port_cycle(0, 0, 0, 1, 4'b0110, 4'd0);
    check_outputs("R9");
    do_read("R9", 4'b0110);
    @(negedge clk_i) mode_i = 0;
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R9");
  endtask

  task automatic t_undefined();
    port_cycle(0, 0, 0, 1, 4'b1010, 4'hA);
    check_outputs("R12");
    do_read("R12", 4'b1010);
    do_read("R12", 4'b1001);
    port_cycle(0, 0, 1, 1, 4'b0001, 4'b1110);
    do_read("R7", 4'b0001);
    port_cycle(0, 1, 0, 1, 0, 0);
    do_read("R7", 4'b0001);
    check("R7", "bit3", int'(rd_data_o[3]), 0);
  endtask

  task automatic t_capture();
    @(negedge clk_i);
    mode_i = 1; cap_i = 1;
    cap_sel_i = 8'b01_00_11_10; cap_en_i = 4'b1010;
    @(negedge clk_i);
    cap_i = 0;
    for (int i = 0; i < P; i++) begin
      a_sel[i] = int'(cap_sel_i[i*SW +: SW]); s_sel[i] = a_sel[i];
      a_en[i] = int'(cap_en_i[i]); s_en[i] = a_en[i];
    end
    check_outputs("R13");
    mode_i = 0;
    port_cycle(0, 1, 0, 1, 0, 0);
    check_outputs("R13");
    do_read("R13", 4'b0011);
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    t_reset();
    t_stage_then_update();
    t_fields();
    t_broadcast();
    t_transparent();
    t_update_junk();
    t_cs_high();
    t_mode_high();
    t_undefined();
    t_capture();
    do_reset();
    check_outputs("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule